// File: doc/BRIEF.md
# ULPI PHY Suspend and Disconnect Event Sequencer

This block is the PHY-side control that puts the transceiver into its low power state and tells the link about a high-speed host disconnect. It watches the link's register writes. When the suspend-enable bit of the function control register is cleared, the block takes the data bus by raising the direction line. It then lets a fixed number of output clock edges pass before it gates the output clock and signals low power to the power controller. If the link sets the bit again before the countdown ends, the sequence is abandoned and the clock keeps running. If a packet is still being received, the countdown waits until the receive ends.

On the event side, a disconnect-detect pulse from the analog front end counts only while the long end-of-packet window of a start-of-frame transmission is open and the port runs at high speed. An accepted pulse sets the host-disconnect status bit and raises a request to send a receive command to the link. That request stays up until the link-side transmitter acknowledges it.

Top module: `ulpi_lpm_sequencer`

## Requirements
- R1: After reset, dir and lpm_active are 0, clk_en is 1, suspendm is 1, host_disc is 0 and rxcmd_req is 0.
- R2: The suspend-enable bit is bit 6 of the function control register. A write to address 0x04 loads it from data bit 6. A write to 0x05 sets it when data bit 6 is 1. A write to 0x06 clears it when data bit 6 is 1. Writes to any other address leave it unchanged. The suspendm output shows the new value in the cycle after the write.
- R3: In the cycle after suspendm is first seen at 0, dir is 1. dir stays 1 while the suspend sequence is under way.
- R4: Five rising clock edges after the bus takeover, with no receive in progress, clk_en drops to 0 and lpm_active rises to 1. Both stay that way until reset, whatever is written afterwards.
- R5: While rx_busy is 1, the countdown does not advance and dir stays 1. The five edges are counted only once rx_busy is 0.
- R6: If suspendm returns to 1 before the countdown completes, dir is released in the next cycle, the count is cleared and clk_en stays 1. This holds even in the cycle that would have completed the count.
- R7: A disconnect is accepted only when disc_det, eop_win and hs_mode are all 1 at the same edge. An accepted disconnect sets host_disc (bit 0 of the interrupt status register at 0x13) in the next cycle. Any other pulse has no effect.
- R8: An accepted disconnect raises rxcmd_req in the next cycle. rxcmd_req stays high until rxcmd_ack. If an acknowledge and a new accepted disconnect fall in the same cycle, rxcmd_req stays 1.
- R9: host_disc is cleared by a write to 0x13 with data bit 0 set. A write to 0x13 with bit 0 at 0, or a write to another address, leaves it unchanged. If a clearing write and an accepted disconnect fall in the same cycle, host_disc stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY output clock domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe from the link |
| reg_addr | input | 6 | Register write address |
| reg_wdata | input | 8 | Register write data |
| rx_busy | input | 1 | A receive is in progress and holds the bus |
| hs_mode | input | 1 | Port runs at high speed |
| disc_det | input | 1 | Disconnect-detect pulse from the front end |
| eop_win | input | 1 | Long end-of-packet window of a start-of-frame is open |
| rxcmd_ack | input | 1 | Receive command has been sent to the link |
| dir | output | 1 | Bus direction, 1 while the PHY owns the bus |
| clk_en | output | 1 | Output clock enable, 0 once the clock is stopped |
| lpm_active | output | 1 | Low power state reached |
| suspendm | output | 1 | Current suspend-enable bit |
| host_disc | output | 1 | Host-disconnect interrupt status bit |
| rxcmd_req | output | 1 | Pending request to send a receive command |

## Verification
Two functions compete in the same cycle. The first is a clearing write to the status register against a new accepted disconnect. The second is a link acknowledge against a new request. The bench drives these collisions deliberately as rows of its vector table, with the write strobe or acknowledge and the qualified disconnect pulse set together. It expects the set to win in both cases, so host_disc and rxcmd_req stay 1. A second collision is also provoked: the link re-sets the suspend bit so that the sequencer sees it at the same edge that would finish the countdown. The bench judges this by dir dropping while clk_en stays high for the cycles that follow.

// File: rtl/ulpi_lpm_pkg.sv
package ulpi_lpm_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HOLD = 2'd1,
        SQ_HALT = 2'd2
    } sq_state_e;

endpackage

// File: rtl/lpm_fctl_reg.sv
module lpm_fctl_reg #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int FCTL_ADDR = 4,
    parameter int SUSP_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              suspendm_o
);
    localparam logic [ADDR_W-1:0] A_WR  = ADDR_W'(FCTL_ADDR);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(FCTL_ADDR + 1);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(FCTL_ADDR + 2);

    typedef struct packed {
        logic susp;
    } fctl_t;

    fctl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            if (wr_addr_i == A_WR) begin
                r_d.susp = wr_data_i[SUSP_BIT];
            end else if (wr_addr_i == A_SET && wr_data_i[SUSP_BIT]) begin
                r_d.susp = 1'b1;
            end else if (wr_addr_i == A_CLR && wr_data_i[SUSP_BIT]) begin
                r_d.susp = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{susp: 1'b1};
        else        r_q <= r_d;
    end

    assign suspendm_o = r_q.susp;

    // R2
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_WR) |=> (suspendm_o == $past(wr_data_i[SUSP_BIT])));

    // R2
    other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || (wr_addr_i != A_WR && wr_addr_i != A_SET && wr_addr_i != A_CLR))
        |=> $stable(suspendm_o));

endmodule

// File: rtl/lpm_susp_seq.sv
module lpm_susp_seq
    import ulpi_lpm_pkg::*;
#(
    parameter int EDGES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic suspendm_i,
    input  logic rx_busy_i,
    output logic dir_o,
    output logic clk_en_o,
    output logic lpm_o
);
    localparam int CNT_W = $clog2(EDGES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);

    typedef struct packed {
        sq_state_e        st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SQ_IDLE: begin
                s_d.cnt = '0;
                if (!suspendm_i) s_d.st = SQ_HOLD;
            end
            SQ_HOLD: begin
                if (suspendm_i) begin
                    s_d.st  = SQ_IDLE;
                    s_d.cnt = '0;
                end else if (!rx_busy_i) begin
                    if (s_q.cnt == LAST) s_d.st  = SQ_HALT;
                    else                 s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SQ_HALT: s_d = s_q;
            default: s_d = '{st: SQ_IDLE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign dir_o    = rx_busy_i || (s_q.st != SQ_IDLE);
    assign clk_en_o = (s_q.st != SQ_HALT);
    assign lpm_o    = (s_q.st == SQ_HALT);

    // R3
    take_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !suspendm_i |=> dir_o);

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_o |=> (!clk_en_o && dir_o && lpm_o));

    // R5
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_HOLD && rx_busy_i && !suspendm_i) |=> ($stable(s_q.cnt) && clk_en_o));

    // R6
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_HOLD && suspendm_i) |=> (clk_en_o && s_q.cnt == '0));

endmodule

// File: rtl/lpm_disc_evt.sv
module lpm_disc_evt #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter int INT_ADDR = 19,
    parameter int HD_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disc_i,
    input  logic              win_i,
    input  logic              hs_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ack_i,
    output logic              int_o,
    output logic              req_o
);
    localparam logic [ADDR_W-1:0] A_INT = ADDR_W'(INT_ADDR);

    typedef struct packed {
        logic hd;
        logic req;
    } evt_t;

    evt_t e_d, e_q;
    logic accept;
    logic clr;

    always_comb begin
        accept = disc_i && win_i && hs_i;
        clr    = wr_en_i && (wr_addr_i == A_INT) && wr_data_i[HD_BIT];
        e_d    = e_q;
        if (accept)   e_d.hd  = 1'b1;
        else if (clr) e_d.hd  = 1'b0;
        if (accept)     e_d.req = 1'b1;
        else if (ack_i) e_d.req = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign int_o = e_q.hd;
    assign req_o = e_q.req;

    // R7
    accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_o) |-> $past(disc_i && win_i && hs_i));

    // R8
    req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_i && win_i && hs_i) |=> (req_o && int_o));

    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !(disc_i && win_i && hs_i)) |=> !req_o);

    // R9
    status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_INT && wr_data_i[HD_BIT] && !(disc_i && win_i && hs_i))
        |=> !int_o);

endmodule

// File: rtl/ulpi_lpm_sequencer.sv
module ulpi_lpm_sequencer #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int FCTL_ADDR = 4,
    parameter int SUSP_BIT  = 6,
    parameter int INT_ADDR  = 19,
    parameter int HD_BIT    = 0,
    parameter int EDGES     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              rx_busy,
    input  logic              hs_mode,
    input  logic              disc_det,
    input  logic              eop_win,
    input  logic              rxcmd_ack,
    output logic              dir,
    output logic              clk_en,
    output logic              lpm_active,
    output logic              suspendm,
    output logic              host_disc,
    output logic              rxcmd_req
);
    logic susp_w;

    lpm_fctl_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FCTL_ADDR(FCTL_ADDR), .SUSP_BIT(SUSP_BIT)
    ) u_fctl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr), .wr_addr_i(reg_addr),
        .wr_data_i(reg_wdata), .suspendm_o(susp_w)
    );

    lpm_susp_seq #(.EDGES(EDGES)) u_seq (
        .clk(clk), .rst_n(rst_n), .suspendm_i(susp_w), .rx_busy_i(rx_busy),
        .dir_o(dir), .clk_en_o(clk_en), .lpm_o(lpm_active)
    );

    lpm_disc_evt #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_ADDR(INT_ADDR), .HD_BIT(HD_BIT)
    ) u_evt (
        .clk(clk), .rst_n(rst_n), .disc_i(disc_det), .win_i(eop_win), .hs_i(hs_mode),
        .wr_en_i(reg_wr), .wr_addr_i(reg_addr), .wr_data_i(reg_wdata),
        .ack_i(rxcmd_ack), .int_o(host_disc), .req_o(rxcmd_req)
    );

    assign suspendm = susp_w;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (clk_en && !lpm_active));

endmodule

// File: tb/ulpi_lpm_sequencer_tb_top.sv
module ulpi_lpm_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic rx_busy = 1'b0, hs_mode = 1'b0, disc_det = 1'b0, eop_win = 1'b0, rxcmd_ack = 1'b0;
    logic dir, clk_en, lpm_active, suspendm, host_disc, rxcmd_req;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ulpi_lpm_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rx_busy(rx_busy), .hs_mode(hs_mode), .disc_det(disc_det), .eop_win(eop_win),
        .rxcmd_ack(rxcmd_ack), .dir(dir), .clk_en(clk_en), .lpm_active(lpm_active),
        .suspendm(suspendm), .host_disc(host_disc), .rxcmd_req(rxcmd_req)
    );

    typedef struct packed {
        logic       hs, win, disc, ack, wr;
        logic [5:0] addr;
        logic [7:0] data;
        logic       eint, ereq;
    } vec_t;

    // hs win disc ack wr addr data | exp host_disc exp rxcmd_req
    localparam vec_t VECS [NV] = '{
        '{1, 0, 1, 0, 0, 6'h00, 8'h00, 0, 0},  // outside window
        '{0, 1, 1, 0, 0, 6'h00, 8'h00, 0, 0},  // full speed
        '{1, 1, 0, 0, 0, 6'h00, 8'h00, 0, 0},  // window, no pulse
        '{1, 1, 1, 0, 0, 6'h00, 8'h00, 1, 1},  // accepted
        '{0, 0, 0, 1, 0, 6'h00, 8'h00, 1, 0},  // ack
        '{0, 0, 0, 0, 1, 6'h13, 8'h01, 0, 0},  // clear
        '{1, 1, 1, 0, 0, 6'h00, 8'h00, 1, 1},  // accepted
        '{1, 1, 1, 1, 0, 6'h00, 8'h00, 1, 1},  // ack vs new accept
        '{0, 0, 0, 1, 0, 6'h00, 8'h00, 1, 0},  // ack
        '{1, 1, 1, 0, 1, 6'h13, 8'h01, 1, 1},  // clear vs accept
        '{0, 0, 0, 1, 1, 6'h13, 8'h00, 1, 0},  // write bit0 zero
        '{0, 0, 0, 0, 1, 6'h12, 8'h01, 1, 0},  // wrong address
        '{0, 0, 0, 0, 1, 6'h13, 8'h01, 0, 0}   // clear
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        rx_busy = 1'b0; hs_mode = 1'b0; disc_det = 1'b0; eop_win = 1'b0; rxcmd_ack = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 dir", dir, 1'b0);
        check("R1 clk_en", clk_en, 1'b1);
        check("R1 lpm_active", lpm_active, 1'b0);
        check("R1 suspendm", suspendm, 1'b1);
        check("R1 host_disc", host_disc, 1'b0);
        check("R1 rxcmd_req", rxcmd_req, 1'b0);

        // R7 R8 R9 vector table
        for (int i = 0; i < NV; i++) begin
            hs_mode = VECS[i].hs; eop_win = VECS[i].win; disc_det = VECS[i].disc;
            rxcmd_ack = VECS[i].ack; reg_wr = VECS[i].wr;
            reg_addr = VECS[i].addr; reg_wdata = VECS[i].data;
            @(negedge clk);
            check($sformatf("R7 R9 host_disc vec %0d", i), host_disc, VECS[i].eint);
            check($sformatf("R8 rxcmd_req vec %0d", i), rxcmd_req, VECS[i].ereq);
        end
        reg_wr = 1'b0; disc_det = 1'b0; eop_win = 1'b0; rxcmd_ack = 1'b0;
        check("R2 suspendm after status writes", suspendm, 1'b1);

        // R2 register access
        do_reset();
        wr(6'h05, 8'h00); check("R2 set addr bit6 zero", suspendm, 1'b1);
        wr(6'h10, 8'h00); check("R2 other addr", suspendm, 1'b1);
        wr(6'h06, 8'hBF); check("R2 clr addr bit6 zero", suspendm, 1'b1);
        wr(6'h04, 8'hBF); check("R2 direct write 0", suspendm, 1'b0);
        wr(6'h05, 8'h40); check("R2 set addr", suspendm, 1'b1);
        wr(6'h06, 8'h40); check("R2 clr addr", suspendm, 1'b0);
        wr(6'h04, 8'h40); check("R2 direct write 1", suspendm, 1'b1);

        // R3 R4 full suspend entry
        do_reset();
        wr(6'h04, 8'h00);
        check("R3 dir before takeover", dir, 1'b0);
        tick(1);
        check("R3 dir after takeover", dir, 1'b1);
        for (int e = 1; e <= 4; e++) begin
            tick(1);
            check($sformatf("R4 clk_en edge %0d", e), clk_en, 1'b1);
            check($sformatf("R3 dir edge %0d", e), dir, 1'b1);
        end
        tick(1);
        check("R4 clk_en after 5 edges", clk_en, 1'b0);
        check("R4 lpm_active after 5 edges", lpm_active, 1'b1);
        wr(6'h05, 8'h40);
        tick(3);
        check("R4 clk_en held", clk_en, 1'b0);
        check("R4 lpm_active held", lpm_active, 1'b1);
        check("R4 dir held", dir, 1'b1);

        // R6 abort at the last edge
        do_reset();
        wr(6'h04, 8'h00);
        tick(1);
        check("R6 dir taken", dir, 1'b1);
        tick(3);
        wr(6'h05, 8'h40);
        check("R6 clk_en before abort", clk_en, 1'b1);
        tick(1);
        check("R6 dir released", dir, 1'b0);
        check("R6 clk_en kept", clk_en, 1'b1);
        tick(10);
        check("R6 clk_en later", clk_en, 1'b1);
        check("R6 lpm_active later", lpm_active, 1'b0);

        // R5 deferral during receive
        do_reset();
        rx_busy = 1'b1;
        wr(6'h06, 8'h40);
        for (int e = 0; e < 8; e++) begin
            tick(1);
            check("R5 clk_en during receive", clk_en, 1'b1);
            check("R5 dir during receive", dir, 1'b1);
        end
        rx_busy = 1'b0;
        #1;
        check("R5 dir after receive end", dir, 1'b1);
        tick(4);
        check("R5 clk_en four edges later", clk_en, 1'b1);
        tick(1);
        check("R5 clk_en five edges later", clk_en, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule